// File: doc/BRIEF.md
# Locality-Hint Line Placement Controller

This block turns a data reference into a placement decision for a cache hierarchy with several levels, each level holding a temporal structure and a non-temporal structure. A request carries the kind of access, a locality hint, the byte address and the level at which the line currently sits. An optional second address comes from post-increment addressing. The block legalizes the hint for the access kind and works out the target level and structure. It then emits a decision record that either commands a move or suppresses it. The cache arrays, miss handling and data movement are outside the block.

Each accepted request yields one record for the primary line. When the post-increment address is valid and lies in a different line, a second record follows for that line. The second record uses the same legalized hint and its own current level. Records leave on a valid/ready stream. A new request is taken only after all records of the previous one have been handed off. Current levels are encoded as 0 for "memory only" and 1..NLVL for a cache level.

Top module: `hint_alloc_ctl`

## Requirements
- R1: After reset `cmd_valid_o` is 0 and `req_ready_o` is 1.
- R2: Hint codes are 0 temporal-L1, 1 non-temporal-L1, 2 non-temporal-L2 and 3 non-temporal-all. They map to these targets (`cmd_lvl_o`, `cmd_nt_o`): code 0 gives (1,0), code 1 gives (1,1), code 2 gives (3,0) and code 3 gives (NLVL,1). `cmd_line_o` is the address with its low log2(LINE_BYTES) bits (5 by default) dropped.
- R3: Kind codes are 0 load, 1 store, 2 prefetch and 3 faulting prefetch. A load with hint 2, or a store with hint 1 or 2, is handled as hint 0. Prefetches accept all four hints.
- R4: `cmd_move_o` is 0 when the current level is nonzero and no greater than the target level. It is 1 when the current level is 0 or greater than the target.
- R5: A target level above NLVL gives `cmd_move_o` = 0.
- R6: With `inc_valid_i` set and a different line, a second record with `cmd_imp_o` = 1 carries the line of `inc_addr_i`, the legalized hint of the request and the no-demotion result for `inc_lvl_i`.
- R7: When `inc_addr_i` lies in the same line as `req_addr_i`, only the primary record is emitted.
- R8: `cmd_flt_o` is 1 only on the primary record of a kind-3 request. It is 0 on every other record.
- R9: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the record holds stable. `req_ready_o` is 0 whenever a record is pending.
- R10: The primary record appears in the cycle after acceptance, before any implicit record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_kind_i | input | 2 | Access kind code |
| req_hint_i | input | 2 | Locality hint code |
| req_addr_i | input | AW | Byte address of the access |
| req_lvl_i | input | LVW | Current level of the primary line |
| inc_valid_i | input | 1 | Post-increment address present |
| inc_addr_i | input | AW | Post-incremented byte address |
| inc_lvl_i | input | LVW | Current level of the post-increment line |
| cmd_valid_o | output | 1 | Decision record valid |
| cmd_ready_i | input | 1 | Downstream takes the record |
| cmd_move_o | output | 1 | Move commanded (0 = suppressed) |
| cmd_line_o | output | LW | Line address |
| cmd_lvl_o | output | LVW | Target level |
| cmd_nt_o | output | 1 | Target is the non-temporal structure |
| cmd_imp_o | output | 1 | Record is for the implicit prefetch |
| cmd_flt_o | output | 1 | Exception check as a 1-byte load is due |

## Verification
The hardest case to reach from the ports is a target past the last level. With the default three levels no hint can produce it. The bench therefore runs a second instance built with two levels next to the main one, and checks that a non-temporal-L2 prefetch is suppressed there. The two-record sequence under back-pressure is reached by dropping `cmd_ready_i` before a request with a distinct post-increment line. The bench then checks that the primary record holds and the request port stays closed.

// File: rtl/hint_alloc_pkg.sv
package hint_alloc_pkg;
  typedef enum logic [1:0] {KIND_LD, KIND_ST, KIND_PF, KIND_PFF} kind_e;
  typedef enum logic [1:0] {HINT_T1, HINT_NT1, HINT_NT2, HINT_NTA} hint_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_PRI, SQ_IMP} sq_e;
endpackage

// File: rtl/hint_legalize.sv
module hint_legalize
  import hint_alloc_pkg::*;
(
  input  kind_e kind_i,
  input  hint_e hint_i,
  output hint_e hint_o
);
  always_comb begin
    hint_o = hint_i;
    unique case (kind_i)
      KIND_LD: if (hint_i == HINT_NT2) hint_o = HINT_T1;
      KIND_ST: if (hint_i == HINT_NT1 || hint_i == HINT_NT2) hint_o = HINT_T1;
      default: ;
    endcase
  end
endmodule

// File: rtl/place_decide.sv
module place_decide
  import hint_alloc_pkg::*;
#(
  parameter int unsigned NLVL = 3,
  parameter int unsigned LVW  = 3
) (
  input  hint_e           hint_i,
  input  logic [LVW-1:0]  cur_i,
  output logic [LVW-1:0]  lvl_o,
  output logic            nt_o,
  output logic            move_o
);
  localparam logic [LVW-1:0] LV1 = LVW'(1);
  localparam logic [LVW-1:0] LV3 = LVW'(3);
  localparam logic [LVW-1:0] LVN = LVW'(NLVL);

  always_comb begin
    unique case (hint_i)
      HINT_T1:  begin lvl_o = LV1; nt_o = 1'b0; end
      HINT_NT1: begin lvl_o = LV1; nt_o = 1'b1; end
      HINT_NT2: begin lvl_o = LV3; nt_o = 1'b0; end  // non-temporal at 2 => temporal at 3
      default:  begin lvl_o = LVN; nt_o = 1'b1; end
    endcase
  end

  // never demote; nothing past the last level
  assign move_o = (lvl_o <= LVN) && ((cur_i == '0) || (cur_i > lvl_o));
endmodule

// File: rtl/hint_alloc_ctl.sv
module hint_alloc_ctl
  import hint_alloc_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned NLVL       = 3,
  localparam int unsigned OFS       = $clog2(LINE_BYTES),
  localparam int unsigned LW        = AW - OFS,
  localparam int unsigned LVW       = $clog2(NLVL + 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [1:0]      req_kind_i,
  input  logic [1:0]      req_hint_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [LVW-1:0]  req_lvl_i,
  input  logic            inc_valid_i,
  input  logic [AW-1:0]   inc_addr_i,
  input  logic [LVW-1:0]  inc_lvl_i,
  output logic            cmd_valid_o,
  input  logic            cmd_ready_i,
  output logic            cmd_move_o,
  output logic [LW-1:0]   cmd_line_o,
  output logic [LVW-1:0]  cmd_lvl_o,
  output logic            cmd_nt_o,
  output logic            cmd_imp_o,
  output logic            cmd_flt_o
);
  localparam int unsigned NPATH = 2;

  hint_e eff_hint;
  logic [NPATH-1:0][LVW-1:0] cur_lv, tgt_lv;
  logic [NPATH-1:0]          tgt_nt, tgt_mv;
  logic [NPATH-1:0][LW-1:0]  path_line;
  logic [AW-1:0]             addr_x;
  logic                      same_line;

  hint_legalize u_legal (
    .kind_i (kind_e'(req_kind_i)),
    .hint_i (hint_e'(req_hint_i)),
    .hint_o (eff_hint)
  );

  assign cur_lv[0]    = req_lvl_i;
  assign cur_lv[1]    = inc_lvl_i;
  assign path_line[0] = req_addr_i[AW-1:OFS];
  assign path_line[1] = inc_addr_i[AW-1:OFS];

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    place_decide #(.NLVL(NLVL), .LVW(LVW)) u_dec (
      .hint_i (eff_hint),
      .cur_i  (cur_lv[p]),
      .lvl_o  (tgt_lv[p]),
      .nt_o   (tgt_nt[p]),
      .move_o (tgt_mv[p])
    );
  end

  assign addr_x    = req_addr_i ^ inc_addr_i;
  assign same_line = (addr_x >> OFS) == '0;

  sq_e            sq_q;
  logic           imp_pend_q;
  logic [LW-1:0]  pri_line_q, imp_line_q;
  logic [LVW-1:0] pri_lvl_q, imp_lvl_q;
  logic           pri_nt_q, imp_nt_q, pri_mv_q, imp_mv_q, pri_flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q       <= SQ_IDLE;
      imp_pend_q <= 1'b0;
      pri_line_q <= '0;
      imp_line_q <= '0;
      pri_lvl_q  <= '0;
      imp_lvl_q  <= '0;
      pri_nt_q   <= 1'b0;
      imp_nt_q   <= 1'b0;
      pri_mv_q   <= 1'b0;
      imp_mv_q   <= 1'b0;
      pri_flt_q  <= 1'b0;
    end else begin
      unique case (sq_q)
        SQ_IDLE: if (req_valid_i) begin
          sq_q       <= SQ_PRI;
          imp_pend_q <= inc_valid_i && !same_line;
          pri_line_q <= path_line[0];
          imp_line_q <= path_line[1];
          pri_lvl_q  <= tgt_lv[0];
          imp_lvl_q  <= tgt_lv[1];
          pri_nt_q   <= tgt_nt[0];
          imp_nt_q   <= tgt_nt[1];
          pri_mv_q   <= tgt_mv[0];
          imp_mv_q   <= tgt_mv[1];
          pri_flt_q  <= (req_kind_i == KIND_PFF);
        end
        SQ_PRI: if (cmd_ready_i) sq_q <= imp_pend_q ? SQ_IMP : SQ_IDLE;
        SQ_IMP: if (cmd_ready_i) sq_q <= SQ_IDLE;
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready_o = (sq_q == SQ_IDLE);
  assign cmd_valid_o = (sq_q != SQ_IDLE);
  assign cmd_imp_o   = (sq_q == SQ_IMP);
  assign cmd_line_o  = cmd_imp_o ? imp_line_q : pri_line_q;
  assign cmd_lvl_o   = cmd_imp_o ? imp_lvl_q  : pri_lvl_q;
  assign cmd_nt_o    = cmd_imp_o ? imp_nt_q   : pri_nt_q;
  assign cmd_move_o  = cmd_imp_o ? imp_mv_q   : pri_mv_q;
  assign cmd_flt_o   = cmd_imp_o ? 1'b0       : pri_flt_q;
endmodule

// File: rtl/hint_alloc_ctl_chk.sv
module hint_alloc_ctl_chk #(
  parameter int unsigned NLVL = 3,
  parameter int unsigned LVW  = 3,
  parameter int unsigned LW   = 27
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic           cmd_valid_o,
  input logic           cmd_ready_i,
  input logic           cmd_move_o,
  input logic [LW-1:0]  cmd_line_o,
  input logic [LVW-1:0] cmd_lvl_o,
  input logic           cmd_nt_o,
  input logic           cmd_imp_o,
  input logic           cmd_flt_o
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_line_o) &&
      $stable(cmd_lvl_o) && $stable(cmd_nt_o) && $stable(cmd_move_o) &&
      $stable(cmd_imp_o) && $stable(cmd_flt_o)));

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !req_ready_o);

  assert_flt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_imp_o) |-> !cmd_flt_o);

  assert_past_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && (int'(cmd_lvl_o) > int'(NLVL))) |-> !cmd_move_o);

  assert_nt_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_nt_o) |-> (int'(cmd_lvl_o) == 1 || int'(cmd_lvl_o) == int'(NLVL)));

  assert_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (cmd_valid_o && !cmd_imp_o));

  assert_order_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_imp_o && !$past(cmd_valid_o && cmd_imp_o)) |->
      $past(cmd_valid_o && !cmd_imp_o && cmd_ready_i));
endmodule

bind hint_alloc_ctl hint_alloc_ctl_chk #(.NLVL(NLVL), .LVW(LVW), .LW(LW)) u_chk (.*);

// File: tb/hint_alloc_ctl_bench.sv
module hint_alloc_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int OFS  = 5;
  localparam int LW   = AW - OFS;
  localparam int NLVL = 3;
  localparam int LVW  = $clog2(NLVL + 2);
  localparam int LVW2 = $clog2(2 + 2);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, inc_valid = 0, cmd_ready = 1;
  logic [1:0] req_kind = 0, req_hint = 0;
  logic [AW-1:0] req_addr = 0, inc_addr = 0;
  logic [LVW-1:0] req_lvl = 0, inc_lvl = 0;

  logic req_ready, cmd_valid, cmd_move, cmd_nt, cmd_imp, cmd_flt;
  logic [LW-1:0] cmd_line;
  logic [LVW-1:0] cmd_lvl;

  logic r2_ready, r2_valid, r2_move, r2_nt, r2_imp, r2_flt;
  logic [LW-1:0] r2_line;
  logic [LVW2-1:0] r2_lvl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hint_alloc_ctl u_hint_alloc_ctl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_hint_i(req_hint), .req_addr_i(req_addr),
    .req_lvl_i(req_lvl), .inc_valid_i(inc_valid), .inc_addr_i(inc_addr),
    .inc_lvl_i(inc_lvl), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_move_o(cmd_move), .cmd_line_o(cmd_line), .cmd_lvl_o(cmd_lvl),
    .cmd_nt_o(cmd_nt), .cmd_imp_o(cmd_imp), .cmd_flt_o(cmd_flt));

  hint_alloc_ctl #(.NLVL(2)) u_hint_alloc_ctl_l2 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(r2_ready),
    .req_kind_i(req_kind), .req_hint_i(req_hint), .req_addr_i(req_addr),
    .req_lvl_i(req_lvl[LVW2-1:0]), .inc_valid_i(inc_valid), .inc_addr_i(inc_addr),
    .inc_lvl_i(inc_lvl[LVW2-1:0]), .cmd_valid_o(r2_valid), .cmd_ready_i(cmd_ready),
    .cmd_move_o(r2_move), .cmd_line_o(r2_line), .cmd_lvl_o(r2_lvl),
    .cmd_nt_o(r2_nt), .cmd_imp_o(r2_imp), .cmd_flt_o(r2_flt));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent model of the requirements
  task automatic model(input int kind, input int hint, input int cur, input int nl,
                       output int lvl, output int nt, output int mv);
    int eff;
    eff = hint;
    if (kind == 0 && hint == 2) eff = 0;
    if (kind == 1 && (hint == 1 || hint == 2)) eff = 0;
    case (eff)
      0: begin lvl = 1; nt = 0; end
      1: begin lvl = 1; nt = 1; end
      2: begin lvl = 3; nt = 0; end
      default: begin lvl = nl; nt = 1; end
    endcase
    mv = (lvl <= nl && (cur == 0 || cur > lvl)) ? 1 : 0;
  endtask

  task automatic send(input int kind, input int hint, input logic [AW-1:0] a, input int cur,
                      input bit iv, input logic [AW-1:0] ia, input int icur);
    @(negedge clk);
    req_valid = 1; req_kind = kind[1:0]; req_hint = hint[1:0]; req_addr = a;
    req_lvl = cur[LVW-1:0]; inc_valid = iv; inc_addr = ia; inc_lvl = icur[LVW-1:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; inc_valid = 0;
  endtask

  // sampled at a negedge; consumes the record at the next posedge
  task automatic expect_rec(input string tag, input bit imp, input int kind, input int hint,
                            input logic [AW-1:0] a, input int cur);
    int lvl, nt, mv;
    model(kind, hint, cur, NLVL, lvl, nt, mv);
    chk({tag, " valid"}, cmd_valid, 1);
    chk({tag, " imp R10"}, cmd_imp, imp);
    chk({tag, " line"}, cmd_line, a >> OFS);
    chk({tag, " lvl"}, cmd_lvl, lvl);
    chk({tag, " nt"}, cmd_nt, nt);
    chk({tag, " move"}, cmd_move, mv);
    chk({tag, " flt R8"}, cmd_flt, (kind == 3 && !imp) ? 1 : 0);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_idle(input string tag);
    chk({tag, " idle valid"}, cmd_valid, 0);
    chk({tag, " idle ready"}, req_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid after reset", cmd_valid, 0);
    chk("R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_hint_map();
    for (int h = 0; h < 4; h++) begin
      logic [AW-1:0] a;
      a = 32'h0001_0000 + 32'(h) * 32'h1234 + 32'h1f;
      send(2, h, a, 0, 0, 0, 0);
      expect_rec("R2 prefetch hint", 0, 2, h, a, 0);
      expect_idle("R2");
    end
    send(0, 1, 32'hdead_beef, 0, 0, 0, 0);
    expect_rec("R2 load nt1", 0, 0, 1, 32'hdead_beef, 0);
  endtask

  task automatic t_legal();
    send(0, 2, 32'h0000_4040, 0, 0, 0, 0);
    expect_rec("R3 load nt2->t1", 0, 0, 2, 32'h0000_4040, 0);
    send(1, 1, 32'h0000_5000, 0, 0, 0, 0);
    expect_rec("R3 store nt1->t1", 0, 1, 1, 32'h0000_5000, 0);
    send(1, 2, 32'h0000_6000, 0, 0, 0, 0);
    expect_rec("R3 store nt2->t1", 0, 1, 2, 32'h0000_6000, 0);
    send(1, 3, 32'h0000_7000, 0, 0, 0, 0);
    expect_rec("R3 store nta kept", 0, 1, 3, 32'h0000_7000, 0);
  endtask

  task automatic t_no_demote();
    send(2, 0, 32'h100, 1, 0, 0, 0);
    expect_rec("R4 t1 at l1", 0, 2, 0, 32'h100, 1);
    send(2, 0, 32'h200, 2, 0, 0, 0);
    expect_rec("R4 t1 from l2", 0, 2, 0, 32'h200, 2);
    send(2, 2, 32'h300, 3, 0, 0, 0);
    expect_rec("R4 nt2 at l3", 0, 2, 2, 32'h300, 3);
    send(2, 2, 32'h400, 1, 0, 0, 0);
    expect_rec("R4 nt2 closer l1", 0, 2, 2, 32'h400, 1);
    send(2, 3, 32'h500, 4, 0, 0, 0);
    expect_rec("R4 nta from beyond", 0, 2, 3, 32'h500, 4);
  endtask

  task automatic t_past_last();
    send(2, 2, 32'h900, 0, 0, 0, 0);
    chk("R5 two-level valid", r2_valid, 1);
    chk("R5 two-level nt2 no move", r2_move, 0);
    chk("R5 two-level nt2 lvl", r2_lvl, 3);
    expect_rec("R5 three-level nt2", 0, 2, 2, 32'h900, 0);
    send(2, 3, 32'ha00, 0, 0, 0, 0);
    chk("R5 two-level nta lvl", r2_lvl, 2);
    chk("R5 two-level nta move", r2_move, 1);
    expect_rec("R5 three-level nta", 0, 2, 3, 32'ha00, 0);
  endtask

  task automatic t_implicit();
    send(0, 1, 32'h1000, 0, 1, 32'h1020, 2);
    expect_rec("R6 load primary", 0, 0, 1, 32'h1000, 0);
    expect_rec("R6 load implicit", 1, 0, 1, 32'h1020, 2);
    expect_idle("R6");
    send(1, 2, 32'h2000, 3, 1, 32'h2100, 1);
    expect_rec("R6 store primary", 0, 1, 2, 32'h2000, 3);
    expect_rec("R6 store implicit legal", 1, 1, 2, 32'h2100, 1);
  endtask

  task automatic t_same_line();
    send(2, 0, 32'h3000, 0, 1, 32'h301f, 0);
    expect_rec("R7 primary", 0, 2, 0, 32'h3000, 0);
    expect_idle("R7 single record");
  endtask

  task automatic t_fault();
    send(3, 3, 32'h4000, 0, 1, 32'h4040, 0);
    expect_rec("R8 faulting primary", 0, 3, 3, 32'h4000, 0);
    expect_rec("R8 faulting implicit", 1, 3, 3, 32'h4040, 0);
    send(2, 3, 32'h5000, 0, 0, 0, 0);
    expect_rec("R8 plain prefetch", 0, 2, 3, 32'h5000, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    cmd_ready = 0;
    send(2, 1, 32'h6000, 0, 1, 32'h6080, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R9 held valid", cmd_valid, 1);
      chk("R9 held primary", cmd_imp, 0);
      chk("R9 held line", cmd_line, 32'h6000 >> OFS);
      chk("R9 request closed", req_ready, 0);
      @(negedge clk);
    end
    cmd_ready = 1;
    expect_rec("R9 released primary", 0, 2, 1, 32'h6000, 0);
    expect_rec("R9 released implicit", 1, 2, 1, 32'h6080, 0);
    expect_idle("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hint_map();
    t_legal();
    t_no_demote();
    t_past_last();
    t_implicit();
    t_same_line();
    t_fault();
    t_backpressure();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule